// File: doc/BRIEF.md
# I2C Serial Memory Slave Protocol Engine

This block is the bus-facing controller of a 256-byte two-wire serial memory. A fast system clock oversamples the SCL and SDA lines. The engine finds start and stop conditions and shifts bytes in MSB first. It decides whether a select byte addresses this device, either through the memory type code or through the protection type code. It then drives the acknowledge slot on an open-drain enable and captures the word address. Each written data byte is handed to a downstream page buffer, and reads are served from a read port of the array.

A write transaction is a select byte with the direction bit clear, then a word address, then one or more data bytes. A read starts from the address counter, which is either loaded by a preceding address-only write (random read) or left from the last access (current-address read). The master keeps a read going by acknowledging each byte and ends it with a NoAck. While the downstream write cycle is running, the engine stays off the bus so that masters can poll for completion.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the SDA enable is low (line released), the read address is 00h and no write strobe or commit has been issued.
- R2: A select byte is laid out as type code in bits 7..4, chip-enable in bits 3..1 and direction in bit 0 (1 = read), sent MSB first. It is acknowledged (SDA held low during the 9th clock) when the type is 1010b and bits 3..1 equal `strap_i`. Any other select byte is not acknowledged, and every later byte is ignored until the next start.
- R3: Type 0110b is acknowledged only while `prot_id_en_i` is high. A write with this type leaves the address counter unchanged and flags its strobe and commit with `wr_prot_o` high. A read with this type returns FFh.
- R4: In a write, the address byte and every data byte are acknowledged. Each data byte produces a one-cycle `wr_strobe_o`, with `wr_data_o` holding the byte and `wr_addr_o` holding its address.
- R5: Between data bytes of one write, the address advances only in its low 4 bits, so it wraps inside a 16-byte page (1Eh, 1Fh, 10h).
- R6: A stop in the slot right after a data-byte acknowledge pulses `wr_commit_o` for one cycle. A stop mid-byte, or a stop with no data byte, gives no commit.
- R7: Random read: a write select and an address byte, then a repeated start and a read select, return the byte at that address.
- R8: Each byte sent increments the read counter, and the counter keeps its value across transactions, so a current-address read returns the byte after the last one read.
- R9: A master acknowledge continues a read at the next address, and the counter wraps from FFh to 00h.
- R10: After a master NoAck the engine releases SDA and drives nothing on later clocks until a start.
- R11: While `busy_i` is high, SDA is released and no select byte is acknowledged.
- R12: A start seen mid-transfer abandons the partial byte, issues no strobe for it, and begins select-byte reception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Chip-enable strap compared with select bits 3..1 |
| prot_id_en_i | input | 1 | Enables response to the protection type code |
| busy_i | input | 1 | Internal write cycle running |
| rd_addr_o | output | 8 | Read address counter to the array |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |
| wr_addr_o | output | 8 | Address of the byte being handed over |
| wr_data_o | output | 8 | Data byte being handed over |
| wr_strobe_o | output | 1 | One-cycle pulse per accepted data byte |
| wr_prot_o | output | 1 | Strobe/commit targets the protection register |
| wr_commit_o | output | 1 | One-cycle pulse starting the write cycle |

## Verification
The bench drives the lines as a bit-level master. Select bytes vary in the type nibble, the strap bits and the direction, which separates a decode that ignores the strap from one that ignores the type or the protection enable. A three-byte write that starts near the end of a page tells page wrap apart from full increment. A three-byte sequential read from FEh tells counter wrap apart from saturation. Stops are placed after the acknowledge, mid-byte and after the address alone, to pin the one slot that commits. A repeated start placed inside a data byte shows whether the partial byte is dropped.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eng_state_t;

  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_PROT = 4'b0110;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data line moves while clock is held high
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_addr_counter.sv
module i2c_addr_counter #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_full,
  input  logic          inc_page,
  output logic [AW-1:0] value
);
  logic [AW-1:0] page_next;

  generate
    if (PAGE_BITS >= AW) begin : g_flat
      assign page_next = value + AW'(1);
    end else begin : g_paged
      localparam logic [PAGE_BITS-1:0] PONE = 1;
      assign page_next = {value[AW-1:PAGE_BITS], value[PAGE_BITS-1:0] + PONE};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           value <= '0;
    else if (load)     value <= load_val;
    else if (inc_full) value <= value + AW'(1);
    else if (inc_page) value <= page_next;
  end

  // R9: read advance is a plain +1 that wraps at the top
  a_r9_read_step: assert property (@(posedge clk) disable iff (rst)
    inc_full && !load |=> value == $past(value) + AW'(1));

  // R7: an address byte lands in the counter
  a_r7_addr_load: assert property (@(posedge clk) disable iff (rst)
    load |=> value == $past(load_val));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_slv_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int CE_W        = 3,
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [CE_W-1:0] strap_i,
  input  logic            prot_id_en_i,
  input  logic            busy_i,
  output logic [AW-1:0]   rd_addr_o,
  input  logic [DW-1:0]   rd_data_i,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            wr_strobe_o,
  output logic            wr_prot_o,
  output logic            wr_commit_o
);
  localparam int BCW = $clog2(DW + 2);
  localparam int TW  = DW - CE_W - 1;
  localparam logic [BCW-1:0] LAST = BCW'(DW);
  localparam logic [BCW-1:0] ACKS = BCW'(DW + 1);
  localparam logic [BCW-1:0] ONE  = BCW'(1);

  // ---- line conditioning ----
  logic [1:0] raw_lines, sync_lines;
  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_sync
      i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk(clk), .rst(rst), .din(raw_lines[g]), .dout(sync_lines[g]));
    end
  endgenerate

  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  assign scl_s = sync_lines[0];
  assign sda_s = sync_lines[1];

  i2c_bus_events i_events (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop));

  // ---- address counter ----
  logic          cnt_load, cnt_inc_full, cnt_inc_page;
  logic [DW-1:0] sh;

  i2c_addr_counter #(.AW(AW), .PAGE_BITS(PAGE_BITS)) i_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(sh[AW-1:0]),
    .inc_full(cnt_inc_full), .inc_page(cnt_inc_page), .value(rd_addr_o));

  // ---- protocol engine ----
  eng_state_t     state;
  logic [BCW-1:0] bitcnt;
  logic           is_prot, rd_mode, wr_seen;
  logic           sel_mem, sel_prot, sel_ok;
  logic [DW-1:0]  tx_next;

  assign sel_mem  = sh[DW-1 -: TW] == TYPE_MEM;
  assign sel_prot = (sh[DW-1 -: TW] == TYPE_PROT) && prot_id_en_i;
  assign sel_ok   = (sel_mem || sel_prot) && (sh[CE_W:1] == strap_i);
  assign tx_next  = is_prot ? {DW{1'b1}} : rd_data_i;

  always_ff @(posedge clk) begin
    wr_strobe_o  <= 1'b0;
    wr_commit_o  <= 1'b0;
    cnt_load     <= 1'b0;
    cnt_inc_full <= 1'b0;
    cnt_inc_page <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      sda_oe_o  <= 1'b0;
      is_prot   <= 1'b0;
      rd_mode   <= 1'b0;
      wr_seen   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_prot_o <= 1'b0;
    end else if (busy_i) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (ev_start) begin
      state    <= ST_SEL;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
      wr_seen  <= 1'b0;
    end else if (ev_stop) begin
      // the stop's own clock rise is counted as one bit of the next byte
      if (state == ST_WDATA && wr_seen && bitcnt == ONE) wr_commit_o <= 1'b1;
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (state == ST_RDATA) begin
      if (scl_rise) begin
        if (bitcnt < LAST) bitcnt <= bitcnt + ONE;
        else if (bitcnt == LAST) begin
          if (!sda_s) bitcnt <= ACKS;
          else        state  <= ST_IDLE;
        end
      end else if (scl_fall) begin
        if (bitcnt != '0 && bitcnt < LAST) begin
          sh       <= {sh[DW-2:0], 1'b0};
          sda_oe_o <= ~sh[DW-2];
        end else if (bitcnt == LAST) begin
          sda_oe_o <= 1'b0;
        end else if (bitcnt == ACKS) begin
          bitcnt       <= '0;
          sh           <= tx_next;
          sda_oe_o     <= ~tx_next[DW-1];
          cnt_inc_full <= !is_prot;
        end
      end
    end else if (state != ST_IDLE) begin
      if (scl_rise && bitcnt < LAST) begin
        sh     <= {sh[DW-2:0], sda_s};
        bitcnt <= bitcnt + ONE;
      end else if (scl_fall && bitcnt == LAST) begin
        bitcnt   <= ACKS;
        sda_oe_o <= 1'b1;
        case (state)
          ST_SEL: begin
            if (sel_ok) begin
              is_prot <= sel_prot;
              rd_mode <= sh[0];
            end else begin
              state    <= ST_IDLE;
              sda_oe_o <= 1'b0;
            end
          end
          ST_ADDR:  cnt_load <= !is_prot;
          ST_WDATA: begin
            wr_strobe_o  <= 1'b1;
            wr_data_o    <= sh;
            wr_addr_o    <= rd_addr_o;
            wr_prot_o    <= is_prot;
            cnt_inc_page <= !is_prot;
            wr_seen      <= 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall && bitcnt == ACKS) begin
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
        case (state)
          ST_SEL: begin
            if (rd_mode) begin
              state        <= ST_RDATA;
              sh           <= tx_next;
              sda_oe_o     <= ~tx_next[DW-1];
              cnt_inc_full <= !is_prot;
            end else begin
              state <= ST_ADDR;
            end
          end
          ST_ADDR: state <= ST_WDATA;
          default: ;
        endcase
      end
    end
  end

  // R1: line released and counter cleared when reset drops
  a_r1_reset_released: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sda_oe_o && rd_addr_o == '0);

  // R11: nothing driven one cycle into a busy period
  a_r11_busy_silent: assert property (@(posedge clk) disable iff (rst)
    $past(busy_i) |-> !sda_oe_o);

  // R4: a handed-over byte is always acknowledged on the bus
  a_r4_strobe_with_ack: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |-> sda_oe_o);

  // R6: commit is a single-cycle pulse
  a_r6_commit_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_commit_o |=> !wr_commit_o);
endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  logic       clk = 1'b0;
  logic       rst;
  logic       scl_m, sda_m;
  logic       sda_oe;
  logic [2:0] strap;
  logic       prot_en, busy;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic       wr_strobe, wr_prot, wr_commit;
  logic       sda_line;
  logic       done = 1'b0;

  int n_chk = 0, n_err = 0, n_str = 0, n_commit = 0;
  logic [7:0] mem [256];
  logic [7:0] log_addr [64];
  logic [7:0] log_data [64];
  logic       log_prot [64];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  i2c_mem_slave i_i2c_mem_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .prot_id_en_i(prot_en), .busy_i(busy),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strobe_o(wr_strobe),
    .wr_prot_o(wr_prot), .wr_commit_o(wr_commit));

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(negedge clk) begin
    if (!rst && wr_strobe) begin
      if (n_str < 64) begin
        log_addr[n_str] = wr_addr;
        log_data[n_str] = wr_data;
        log_prot[n_str] = wr_prot;
      end
      if (!wr_prot) mem[wr_addr] = wr_data;
      n_str++;
    end
    if (!rst && wr_commit) n_commit++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start;
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    tick(4); sda_m = b; tick(4);
    scl_m = 1'b1; tick(4);
    s = sda_line; tick(4);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  task automatic t_reset;
    check("R1 sda released", sda_oe, 0);
    check("R1 counter", rd_addr, 0);
    check("R1 no strobe", n_str, 0);
  endtask

  task automatic t_write_page;
    logic a;
    do_start;
    send_byte(8'hAA, a); check("R2 select ack", a, 1);
    send_byte(8'h1E, a); check("R4 addr ack", a, 1);
    send_byte(8'h11, a); check("R4 data ack", a, 1);
    send_byte(8'h22, a); check("R4 data ack", a, 1);
    send_byte(8'h33, a); check("R4 data ack", a, 1);
    do_stop; tick(8);
    check("R4 strobe count", n_str, 3);
    check("R5 addr0", log_addr[0], 8'h1E);
    check("R5 addr1", log_addr[1], 8'h1F);
    check("R5 page wrap", log_addr[2], 8'h10);
    check("R4 data0", log_data[0], 8'h11);
    check("R4 data2", log_data[2], 8'h33);
    check("R4 target", log_prot[0], 0);
    check("R6 commit", n_commit, 1);
  endtask

  task automatic t_nomatch;
    logic a;
    do_start;
    send_byte(8'hA8, a); check("R2 strap mismatch nack", a, 0);
    send_byte(8'hAA, a); check("R2 ignored until start", a, 0);
    do_stop;
    do_start;
    send_byte(8'hEA, a); check("R2 wrong type nack", a, 0);
    do_stop; tick(8);
    check("R2 no strobe", n_str, 3);
  endtask

  task automatic t_prot;
    logic a;
    logic [7:0] d;
    prot_en = 1'b0;
    do_start;
    send_byte(8'h6A, a); check("R3 disabled nack", a, 0);
    do_stop;
    prot_en = 1'b1;
    do_start;
    send_byte(8'h6A, a); check("R3 enabled ack", a, 1);
    send_byte(8'h77, a); check("R3 addr ack", a, 1);
    send_byte(8'h00, a); check("R3 data ack", a, 1);
    do_stop; tick(8);
    check("R3 strobe", n_str, 4);
    check("R3 strobe target", log_prot[3], 1);
    check("R3 commit", n_commit, 2);
    check("R3 counter kept", rd_addr, 8'h11);
    do_start;
    send_byte(8'h6B, a); check("R3 read ack", a, 1);
    recv_byte(1'b0, d); check("R3 read value", d, 8'hFF);
    do_stop; tick(8);
    check("R3 counter after read", rd_addr, 8'h11);
    prot_en = 1'b0;
  endtask

  task automatic t_commit_neg;
    logic a, s;
    do_start;
    send_byte(8'hAA, a);
    send_byte(8'h60, a);
    do_stop; tick(8);
    check("R6 no data no commit", n_commit, 2);
    do_start;
    send_byte(8'hAA, a);
    send_byte(8'h60, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    do_stop; tick(8);
    check("R6 mid-byte no commit", n_commit, 2);
    check("R6 partial no strobe", n_str, 4);
  endtask

  task automatic t_random;
    logic a;
    logic [7:0] d;
    do_start;
    send_byte(8'hAA, a);
    send_byte(8'h40, a);
    do_start;
    send_byte(8'hAB, a); check("R7 read select ack", a, 1);
    recv_byte(1'b0, d); check("R7 random data", d, 8'h1A);
    do_stop; tick(8);
    check("R8 counter advanced", rd_addr, 8'h41);
  endtask

  task automatic t_current;
    logic a;
    logic [7:0] d;
    do_start;
    send_byte(8'hAB, a); check("R8 select ack", a, 1);
    recv_byte(1'b0, d); check("R8 current data", d, 8'h1B);
    do_stop; tick(8);
    check("R8 counter", rd_addr, 8'h42);
  endtask

  task automatic t_seq_wrap;
    logic a, s;
    logic [7:0] d;
    logic [8:0] idle_bits;
    do_start;
    send_byte(8'hAA, a);
    send_byte(8'hFE, a);
    do_start;
    send_byte(8'hAB, a);
    recv_byte(1'b1, d); check("R9 byte FE", d, 8'hA4);
    recv_byte(1'b1, d); check("R9 byte FF", d, 8'hA5);
    recv_byte(1'b0, d); check("R9 wrap to 00", d, 8'h5A);
    for (int i = 8; i >= 0; i--) begin
      clk_bit(1'b1, s);
      idle_bits[i] = s;
    end
    check("R10 released after NoAck", idle_bits, 9'h1FF);
    do_stop; tick(8);
    check("R9 counter wrapped", rd_addr, 8'h01);
  endtask

  task automatic t_busy;
    logic a;
    logic [7:0] d;
    busy = 1'b1; tick(4);
    do_start;
    send_byte(8'hAA, a); check("R11 busy nack", a, 0);
    do_stop;
    busy = 1'b0; tick(4);
    do_start;
    send_byte(8'hAB, a); check("R11 ack after busy", a, 1);
    recv_byte(1'b0, d); check("R11 data after busy", d, 8'h5B);
    do_stop;
  endtask

  task automatic t_abort;
    logic a, s;
    logic [7:0] d;
    do_start;
    send_byte(8'hAA, a);
    send_byte(8'h50, a);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    do_start;
    send_byte(8'hAB, a); check("R12 select after abort", a, 1);
    recv_byte(1'b0, d); check("R12 data after abort", d, 8'h0A);
    do_stop; tick(8);
    check("R12 no strobe for partial", n_str, 4);
  endtask

  initial begin
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    busy = 1'b0; prot_en = 1'b0; strap = 3'b101;
    tick(5);
    rst = 1'b0;
    tick(4);
    t_reset;
    t_write_page;
    t_nomatch;
    t_prot;
    t_commit_neg;
    t_random;
    t_current;
    t_seq_wrap;
    t_busy;
    t_abort;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule